// File: doc/BRIEF.md
# Per-Pixel Alpha and Depth Test Stage

This block sits in a pixel pipeline between rasterisation and the frame-buffer write port. Each cycle it may accept one pixel. A pixel arrives with its source alpha, its incoming depth, the depth already stored at its location and the top bit of the alpha already stored in the colour buffer. It also receives a 64-bit test configuration word and a depth write mask. One cycle later the block gives three write enables: colour RGB, colour alpha and depth. A later memory stage uses them.

The decision is made in three steps. First, two comparators give an alpha verdict and a depth verdict. Second, a selector turns those verdicts, the destination-alpha check and the alpha-failure action into one named outcome:

- `V_DROP`: nothing is written.
- `V_FULL`: RGB, alpha and depth are written.
- `V_COLOUR`: RGB and alpha are written.
- `V_DEPTH`: only depth is written.
- `V_RGB`: only RGB is written.

Third, an output process turns the outcome into the three enables, applies the depth write mask and registers the result together with the valid flag.

A pixel that fails the alpha test is not always discarded. The failure action can still let it update the colour buffer, the depth buffer, or only the RGB channels.

Top module: `pt_test_stage`

## Requirements
- R1: `out_valid` equals `in_valid` from the previous clock. All three enables reflect the pixel presented on that previous clock.
- R2: While `rst_n` is low, and on the first edge after its release with no input, `out_valid` and all three enables are 0.
- R3: Alpha test enable is `cfg[0]`. The alpha method is `cfg[3:1]` and the 8-bit reference is `cfg[11:4]`. With the test enabled, the pixel alpha passes as follows:
  - 0: never
  - 1: always
  - 2: alpha < ref
  - 3: alpha <= ref
  - 4: alpha == ref
  - 5: alpha >= ref
  - 6: alpha > ref
  - 7: alpha != ref
- R4: With `cfg[0]` = 0, every pixel passes the alpha test whatever the method, and the failure action has no effect.
- R5: Depth test enable is `cfg[16]` and the depth method is `cfg[18:17]`. The incoming depth is compared unsigned against the stored depth: 0 never passes, 1 always passes, 2 passes if incoming >= stored, 3 passes if incoming > stored.
- R6: With `cfg[16]` = 0, every pixel passes the depth test.
- R7: The failure action `cfg[13:12]` applies to a pixel that fails the alpha test. Code 0 writes nothing. Code 1 writes RGB and alpha but not depth. Code 2 writes only depth. Code 3 writes only RGB. Each of these writes still requires the depth test to pass.
- R8: A pixel that passes both the alpha and depth tests writes RGB, alpha and depth. A pixel that fails the depth test writes nothing.
- R9: With the destination-alpha check enabled (`cfg[14]` = 1), a pixel whose `in_dst_amsb` differs from the mode bit `cfg[15]` writes nothing.
- R10: With `in_zmask` = 1, `out_z_we` is 0 and the colour enables are unaffected.
- R11: A cycle with `in_valid` = 0 gives all three enables 0 on the next clock.
- R12: Configuration bits 63:19 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A pixel is present this cycle |
| in_alpha | input | 8 | Source alpha of the pixel |
| in_z | input | Z_W | Incoming depth |
| in_zbuf | input | Z_W | Depth stored at the pixel location |
| in_dst_amsb | input | 1 | Top bit of the stored colour alpha |
| in_cfg | input | CFG_W | Test configuration word |
| in_zmask | input | 1 | Depth write mask (1 blocks the depth write) |
| out_valid | output | 1 | Registered pixel valid |
| out_rgb_we | output | 1 | Write enable for colour RGB |
| out_a_we | output | 1 | Write enable for colour alpha |
| out_z_we | output | 1 | Write enable for depth |

## Verification
The assertions check on every cycle the properties that hold for every pixel:
- the one-cycle valid latency;
- no enables on an idle output;
- the effect of the depth mask;
- the rule that alpha is never written without RGB;
- rejection on a destination-alpha mismatch;
- total discard when the depth method is "never" or when an alpha "never" test meets the keep action.

The outcome for each individual case can only be shown by the bench's scenarios, which compare against an independent model. This covers each alpha comparison at, just below and just above the reference, each depth comparison at the equality boundary, and each failure action combined with a passing or failing depth test.

// File: rtl/pt_pkg.sv
package pt_pkg;

    localparam int ALPHA_W = 8;

    // configuration word field positions
    localparam int B_ATE   = 0;
    localparam int B_AMLO  = 1;
    localparam int B_AREF  = 4;
    localparam int B_AFLO  = 12;
    localparam int B_DCHK  = 14;
    localparam int B_DMODE = 15;
    localparam int B_ZTE   = 16;
    localparam int B_ZMLO  = 17;
    localparam int CFG_USED = 19;

    typedef enum logic [2:0] {
        AM_NEVER  = 3'd0,
        AM_ALWAYS = 3'd1,
        AM_LT     = 3'd2,
        AM_LE     = 3'd3,
        AM_EQ     = 3'd4,
        AM_GE     = 3'd5,
        AM_GT     = 3'd6,
        AM_NE     = 3'd7
    } alpha_meth_e;

    typedef enum logic [1:0] {
        ZM_NEVER  = 2'd0,
        ZM_ALWAYS = 2'd1,
        ZM_GE     = 2'd2,
        ZM_GT     = 2'd3
    } depth_meth_e;

    typedef enum logic [1:0] {
        FA_KEEP   = 2'd0,
        FA_COLOUR = 2'd1,
        FA_DEPTH  = 2'd2,
        FA_RGB    = 2'd3
    } fail_act_e;

    typedef enum logic [2:0] {
        V_DROP   = 3'd0,
        V_FULL   = 3'd1,
        V_COLOUR = 3'd2,
        V_DEPTH  = 3'd3,
        V_RGB    = 3'd4
    } verdict_e;

    typedef struct packed {
        logic                ate;
        alpha_meth_e         ameth;
        logic [ALPHA_W-1:0]  aref;
        fail_act_e           afail;
        logic                dchk;
        logic                dmode;
        logic                zte;
        depth_meth_e         zmeth;
    } test_cfg_t;

endpackage

// File: rtl/pt_alpha_cmp.sv
module pt_alpha_cmp
    import pt_pkg::*;
(
    input  logic               en,
    input  alpha_meth_e        meth,
    input  logic [ALPHA_W-1:0] alpha,
    input  logic [ALPHA_W-1:0] aref,
    output logic               pass
);
    always_comb begin
        pass = 1'b1;
        if (en) begin
            unique case (meth)
                AM_NEVER:  pass = 1'b0;
                AM_ALWAYS: pass = 1'b1;
                AM_LT:     pass = (alpha <  aref);
                AM_LE:     pass = (alpha <= aref);
                AM_EQ:     pass = (alpha == aref);
                AM_GE:     pass = (alpha >= aref);
                AM_GT:     pass = (alpha >  aref);
                AM_NE:     pass = (alpha != aref);
                default:   pass = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pt_depth_cmp.sv
module pt_depth_cmp
    import pt_pkg::*;
#(
    parameter int Z_W = 32
) (
    input  logic           en,
    input  depth_meth_e    meth,
    input  logic [Z_W-1:0] z_in,
    input  logic [Z_W-1:0] z_old,
    output logic           pass
);
    always_comb begin
        pass = 1'b1;
        if (en) begin
            unique case (meth)
                ZM_NEVER:  pass = 1'b0;
                ZM_ALWAYS: pass = 1'b1;
                ZM_GE:     pass = (z_in >= z_old);
                ZM_GT:     pass = (z_in >  z_old);
                default:   pass = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pt_verdict.sv
module pt_verdict
    import pt_pkg::*;
(
    input  logic      alpha_pass,
    input  logic      depth_pass,
    input  logic      dst_ok,
    input  fail_act_e afail,
    output verdict_e  verdict
);
    always_comb begin
        if (!dst_ok || !depth_pass) begin
            verdict = V_DROP;
        end else if (alpha_pass) begin
            verdict = V_FULL;
        end else begin
            unique case (afail)
                FA_KEEP:   verdict = V_DROP;
                FA_COLOUR: verdict = V_COLOUR;
                FA_DEPTH:  verdict = V_DEPTH;
                FA_RGB:    verdict = V_RGB;
                default:   verdict = V_DROP;
            endcase
        end
    end
endmodule

// File: rtl/pt_test_stage.sv
module pt_test_stage
    import pt_pkg::*;
#(
    parameter int Z_W   = 32,
    parameter int CFG_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [ALPHA_W-1:0] in_alpha,
    input  logic [Z_W-1:0]     in_z,
    input  logic [Z_W-1:0]     in_zbuf,
    input  logic               in_dst_amsb,
    input  logic [CFG_W-1:0]   in_cfg,
    input  logic               in_zmask,
    output logic               out_valid,
    output logic               out_rgb_we,
    output logic               out_a_we,
    output logic               out_z_we
);
    localparam int SPARE_W = CFG_W - CFG_USED;

    test_cfg_t cfg_q;
    logic      alpha_ok, depth_ok, dst_ok;
    verdict_e  verdict;
    logic      nxt_rgb, nxt_a, nxt_z;

    // field extraction
    assign cfg_q.ate   = in_cfg[B_ATE];
    assign cfg_q.ameth = alpha_meth_e'(in_cfg[B_AMLO +: 3]);
    assign cfg_q.aref  = in_cfg[B_AREF +: ALPHA_W];
    assign cfg_q.afail = fail_act_e'(in_cfg[B_AFLO +: 2]);
    assign cfg_q.dchk  = in_cfg[B_DCHK];
    assign cfg_q.dmode = in_cfg[B_DMODE];
    assign cfg_q.zte   = in_cfg[B_ZTE];
    assign cfg_q.zmeth = depth_meth_e'(in_cfg[B_ZMLO +: 2]);

    generate
        if (SPARE_W > 0) begin : g_spare
            logic unused_spare;
            assign unused_spare = ^in_cfg[CFG_W-1:CFG_USED];
        end
    endgenerate

    assign dst_ok = !cfg_q.dchk || (in_dst_amsb == cfg_q.dmode);

    pt_alpha_cmp u_acmp (
        .en    (cfg_q.ate),
        .meth  (cfg_q.ameth),
        .alpha (in_alpha),
        .aref  (cfg_q.aref),
        .pass  (alpha_ok)
    );

    pt_depth_cmp #(.Z_W(Z_W)) u_zcmp (
        .en    (cfg_q.zte),
        .meth  (cfg_q.zmeth),
        .z_in  (in_z),
        .z_old (in_zbuf),
        .pass  (depth_ok)
    );

    pt_verdict u_sel (
        .alpha_pass (alpha_ok),
        .depth_pass (depth_ok),
        .dst_ok     (dst_ok),
        .afail      (cfg_q.afail),
        .verdict    (verdict)
    );

    // outcome decode
    always_comb begin
        nxt_rgb = 1'b0;
        nxt_a   = 1'b0;
        nxt_z   = 1'b0;
        unique case (verdict)
            V_DROP:   ;
            V_FULL:   begin nxt_rgb = 1'b1; nxt_a = 1'b1; nxt_z = 1'b1; end
            V_COLOUR: begin nxt_rgb = 1'b1; nxt_a = 1'b1; end
            V_DEPTH:  nxt_z = 1'b1;
            V_RGB:    nxt_rgb = 1'b1;
            default:  ;
        endcase
        if (!in_valid) begin
            nxt_rgb = 1'b0;
            nxt_a   = 1'b0;
            nxt_z   = 1'b0;
        end
        if (in_zmask) nxt_z = 1'b0;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_rgb_we <= 1'b0;
            out_a_we   <= 1'b0;
            out_z_we   <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            out_rgb_we <= nxt_rgb;
            out_a_we   <= nxt_a;
            out_z_we   <= nxt_z;
        end
    end
endmodule

// File: rtl/pt_test_stage_chk.sv
module pt_test_stage_chk #(
    parameter int CFG_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_dst_amsb,
    input logic [CFG_W-1:0] in_cfg,
    input logic             in_zmask,
    input logic             out_valid,
    input logic             out_rgb_we,
    input logic             out_a_we,
    input logic             out_z_we
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_rgb_we || out_a_we || out_z_we));
    a_r10_zmask: assert property (@(posedge clk) disable iff (!rst_n)
        in_zmask |=> !out_z_we);
    a_r7_alpha_needs_rgb: assert property (@(posedge clk) disable iff (!rst_n)
        out_a_we |-> out_rgb_we);
    a_r9_dst_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cfg[14] && (in_dst_amsb != in_cfg[15]))
        |=> !(out_rgb_we || out_a_we || out_z_we));
    a_r5_depth_never: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cfg[16] && in_cfg[18:17] == 2'd0)
        |=> !(out_rgb_we || out_a_we || out_z_we));
    a_r7_never_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cfg[0] && in_cfg[3:1] == 3'd0 && in_cfg[13:12] == 2'd0)
        |=> !(out_rgb_we || out_a_we || out_z_we));
endmodule

bind pt_test_stage pt_test_stage_chk #(.CFG_W(CFG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_dst_amsb (in_dst_amsb),
    .in_cfg      (in_cfg),
    .in_zmask    (in_zmask),
    .out_valid   (out_valid),
    .out_rgb_we  (out_rgb_we),
    .out_a_we    (out_a_we),
    .out_z_we    (out_z_we)
);

// File: tb/pt_test_stage_bench.sv
module pt_test_stage_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_alpha = '0;
    logic [31:0] in_z = '0;
    logic [31:0] in_zbuf = '0;
    logic        in_dst_amsb = 1'b0;
    logic [63:0] in_cfg = '0;
    logic        in_zmask = 1'b0;
    logic        out_valid, out_rgb_we, out_a_we, out_z_we;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    pt_test_stage u_pt_test_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_alpha(in_alpha),
        .in_z(in_z), .in_zbuf(in_zbuf), .in_dst_amsb(in_dst_amsb),
        .in_cfg(in_cfg), .in_zmask(in_zmask), .out_valid(out_valid),
        .out_rgb_we(out_rgb_we), .out_a_we(out_a_we), .out_z_we(out_z_we)
    );

    function automatic logic [63:0] mk_cfg(int ate, int am, int aref, int af,
                                           int dchk, int dmode, int zte, int zm);
        logic [63:0] c = '0;
        c[0]     = ate[0];
        c[3:1]   = am[2:0];
        c[11:4]  = aref[7:0];
        c[13:12] = af[1:0];
        c[14]    = dchk[0];
        c[15]    = dmode[0];
        c[16]    = zte[0];
        c[18:17] = zm[1:0];
        return c;
    endfunction

    // behavioural reference: returns {valid, rgb, a, z}
    function automatic logic [3:0] model(logic v, logic [63:0] c, int a,
                                         longint z, longint zb, logic dm, logic zk);
        int  am  = int'(c[3:1]);
        int  ar  = int'(c[11:4]);
        bit  ap, zp, dok;
        bit  r = 0, al = 0, w = 0;
        if (c[0] == 1'b0) ap = 1;
        else case (am)
            0: ap = 0;          1: ap = 1;
            2: ap = a < ar;     3: ap = a <= ar;
            4: ap = a == ar;    5: ap = a >= ar;
            6: ap = a > ar;     default: ap = a != ar;
        endcase
        if (c[16] == 1'b0) zp = 1;
        else case (int'(c[18:17]))
            0: zp = 0;  1: zp = 1;
            2: zp = z >= zb;  default: zp = z > zb;
        endcase
        dok = (c[14] == 1'b0) || (dm == c[15]);
        if (v && dok && zp) begin
            if (ap) begin r = 1; al = 1; w = 1; end
            else case (int'(c[13:12]))
                1: begin r = 1; al = 1; end
                2: w = 1;
                3: r = 1;
                default: ;
            endcase
        end
        if (zk) w = 0;
        return {v, r, al, w};
    endfunction

    // drive at a falling edge, check at the next falling edge
    task automatic apply(logic v, logic [63:0] c, int a, longint z, longint zb,
                         logic dm, logic zk, string tag);
        logic [3:0] exp;
        logic [3:0] got;
        in_valid = v; in_cfg = c; in_alpha = a[7:0];
        in_z = z[31:0]; in_zbuf = zb[31:0]; in_dst_amsb = dm; in_zmask = zk;
        exp = model(v, c, a, z, zb, dm, zk);
        @(negedge clk);
        got = {out_valid, out_rgb_we, out_a_we, out_z_we};
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: {valid,rgb,a,z} actual %b expected %b (cfg=%h alpha=%0d z=%0d zb=%0d)",
                     tag, got, exp, c, a, z, zb);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] c;
        // R2: reset state
        repeat (3) @(negedge clk);
        vectors++;
        if ({out_valid, out_rgb_we, out_a_we, out_z_we} !== 4'b0000) begin
            errors++;
            $display("FAIL R2: actual %b expected 0000",
                     {out_valid, out_rgb_we, out_a_we, out_z_we});
        end
        rst_n = 1'b1;
        apply(0, '0, 0, 0, 0, 0, 0, "R2");

        // R3: every alpha method around the reference
        for (int m = 0; m < 8; m++)
            for (int d = -1; d <= 1; d++)
                apply(1, mk_cfg(1, m, 64, 0, 0, 0, 0, 0), 64 + d, 5, 5, 0, 0, "R3");
        apply(1, mk_cfg(1, 2, 0, 0, 0, 0, 0, 0), 0, 5, 5, 0, 0, "R3");
        apply(1, mk_cfg(1, 6, 255, 0, 0, 0, 0, 0), 255, 5, 5, 0, 0, "R3");

        // R4: alpha test off, failure action irrelevant
        for (int af = 0; af < 4; af++)
            apply(1, mk_cfg(0, 0, 64, af, 0, 0, 0, 0), 3, 5, 5, 0, 0, "R4");

        // R5: every depth method at the equality boundary
        for (int m = 0; m < 4; m++)
            for (int d = -1; d <= 1; d++)
                apply(1, mk_cfg(0, 0, 0, 0, 0, 0, 1, m), 9, 1000 + d, 1000, 0, 0, "R5");
        apply(1, mk_cfg(0, 0, 0, 0, 0, 0, 1, 3), 9, 64'hFFFF_FFFF, 0, 0, 0, "R5");

        // R6: depth test off
        apply(1, mk_cfg(0, 0, 0, 0, 0, 0, 0, 0), 9, 0, 500, 0, 0, "R6");

        // R7: failure actions with depth passing and failing
        for (int af = 0; af < 4; af++) begin
            apply(1, mk_cfg(1, 0, 0, af, 0, 0, 1, 2), 9, 20, 10, 0, 0, "R7");
            apply(1, mk_cfg(1, 0, 0, af, 0, 0, 1, 2), 9, 5, 10, 0, 0, "R7");
            apply(1, mk_cfg(1, 2, 10, af, 0, 0, 0, 0), 50, 5, 10, 0, 0, "R7");
        end

        // R8: alpha pass, depth pass/fail
        apply(1, mk_cfg(1, 5, 10, 3, 0, 0, 1, 3), 50, 11, 10, 0, 0, "R8");
        apply(1, mk_cfg(1, 5, 10, 3, 0, 0, 1, 3), 50, 10, 10, 0, 0, "R8");

        // R9: destination-alpha check
        for (int md = 0; md < 2; md++)
            for (int ms = 0; ms < 2; ms++) begin
                apply(1, mk_cfg(0, 0, 0, 0, 1, md, 0, 0), 1, 1, 1, ms[0], 0, "R9");
                apply(1, mk_cfg(1, 0, 0, 1, 1, md, 0, 0), 1, 1, 1, ms[0], 0, "R9");
            end

        // R10: depth write mask
        apply(1, mk_cfg(0, 0, 0, 0, 0, 0, 0, 0), 1, 1, 1, 0, 1, "R10");
        apply(1, mk_cfg(1, 0, 0, 2, 0, 0, 0, 0), 1, 1, 1, 0, 1, "R10");
        apply(1, mk_cfg(1, 0, 0, 2, 0, 0, 0, 0), 1, 1, 1, 0, 0, "R10");

        // R11: idle cycles with a fully passing setup
        apply(0, mk_cfg(0, 0, 0, 0, 0, 0, 0, 0), 1, 1, 1, 0, 0, "R11");
        apply(1, mk_cfg(0, 0, 0, 0, 0, 0, 0, 0), 1, 1, 1, 0, 0, "R11");
        apply(0, mk_cfg(1, 1, 0, 1, 0, 0, 1, 1), 1, 1, 1, 0, 0, "R11");

        // R12: spare configuration bits set
        for (int i = 0; i < 40; i++) begin
            c = {$urandom, $urandom};
            c[18:0] = mk_cfg(1, i % 8, 100, i % 4, 0, 0, 1, i % 4)[18:0];
            apply(1, c, 90 + (i % 20), 7 + (i % 3), 8, 0, 0, "R12");
        end

        // R1: random streaming, back to back
        for (int i = 0; i < 3000; i++) begin
            c = {$urandom, $urandom};
            apply(($urandom % 4) != 0, c, $urandom % 256,
                  longint'($urandom % 8), longint'($urandom % 8),
                  $urandom % 2, ($urandom % 5) == 0, "R1");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule